// File: doc/BRIEF.md
# Read-Triggered Power-Mode Request Controller

This block is a small slice of a memory-mapped system controller. It sits on a simple register bus with an address, a read strobe, a write strobe, write data and read data. A bus read of one of two dedicated locations asks the rest of the chip to enter a low-power state. One location asks for halt and the other asks for standby. The request is produced only while a separate configuration enable input is high.

The block also holds two latched interrupts. One is for a watchdog-expiry event and one is for a periodic 64 Hz tick event. A write of any value to a third location clears both of them.

Clock gating, oscillator control and wake-up handling live elsewhere. This block only turns bus accesses into single-cycle request pulses and keeps the interrupt flags.

Top module: `pwr_req_ctrl`

## Requirements
- R1: A read of offset 0x08 while `mode_en` is high produces a one-cycle `halt_req` pulse. The pulse is high during the clock cycle that follows the rising edge at which the read was sampled.
- R2: A read of offset 0x0C while `mode_en` is high produces a one-cycle `stby_req` pulse, with the same timing as R1.
- R3: A read of offset 0x08 or 0x0C while `mode_en` is low (as sampled on the first cycle of the read) produces no request and changes no other output.
- R4: A read held on the same address for several consecutive cycles yields exactly one pulse. A new pulse needs the read strobe to drop or the address to change first.
- R5: A write to offset 0x08 or 0x0C produces no request and leaves both interrupt outputs unchanged.
- R6: `bus_rdata` reads as all zeros at every offset.
- R7: A write of any data to offset 0x18 clears both `wdog_irq` and `tick_irq` from the following cycle.
- R8: A one-cycle pulse on `wdog_evt` or `tick_evt` sets the matching interrupt output from the next cycle. The output stays high until it is cleared.
- R9: When an event and a clear write to offset 0x18 land in the same cycle, the interrupt of that event is left set.
- R10: A read or write at any offset other than 0x08, 0x0C and 0x18 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data (value ignored) |
| bus_rdata | output | DATA_W (32) | Read data, always zero |
| mode_en | input | 1 | Enable for low-power mode entry |
| wdog_evt | input | 1 | Watchdog-expiry event pulse |
| tick_evt | input | 1 | 64 Hz tick event pulse |
| wdog_irq | output | 1 | Latched watchdog interrupt |
| tick_irq | output | 1 | Latched tick interrupt |
| halt_req | output | 1 | One-cycle halt request |
| stby_req | output | 1 | One-cycle standby request |

## Verification
The bench reads every offset with the enable both low and high, and holds some reads for three cycles. This catches a decoder that aliases an address, a request that ignores the enable, and a request that repeats on every cycle of a held read. It writes every offset with varied data while both interrupts are set, so a clear that decodes too loosely, or writes to the mode locations that do something, would show up. It also drives an event in the same cycle as a clear, where a design that gives the clear priority would lose the interrupt.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;

    localparam int NUM_MODES = 2;   // index 0: halt, index 1: standby
    localparam int NUM_IRQS  = 2;   // index 0: watchdog, index 1: tick

    typedef struct packed {
        logic prev;   // matching read seen in previous cycle
        logic req;    // registered request pulse
    } pulse_st_t;

endpackage

// File: rtl/pwr_addr_dec.sv
module pwr_addr_dec
    import pwr_req_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HALT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] STBY_OFS = 8'h0C,
    parameter logic [ADDR_W-1:0] CLR_OFS  = 8'h18
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    output logic [NUM_MODES-1:0] mode_rd_o,
    output logic                 clr_wr_o
);

    localparam logic [ADDR_W-1:0] MODE_OFS [NUM_MODES] = '{HALT_OFS, STBY_OFS};

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        always_comb mode_rd_o[m] = rd_i && (addr_i == MODE_OFS[m]);
    end

    always_comb clr_wr_o = wr_i && (addr_i == CLR_OFS);

endmodule

// File: rtl/pwr_req_pulse.sv
module pwr_req_pulse
    import pwr_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic en_i,
    output logic req_o
);

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe_i;
        st_d.req  = strobe_i && !st_q.prev && en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R4: a request never lasts more than one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R3: a request only follows a cycle in which the enable was high
    a_r3_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !req_o);

    // R1/R2: a fresh enabled read yields a request next cycle
    a_r1_fresh_read_req: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && en_i && !st_q.prev) |=> req_o);

endmodule

// File: rtl/pwr_irq_latch.sv
module pwr_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr_i) irq_d = 1'b0;
        if (set_i) irq_d = 1'b1;   // set has priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R8: an event sets the flag, and it stays set until cleared
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);

    // R7: a clear without a concurrent event drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o);

    // R9: set wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i) |=> irq_o);

endmodule

// File: rtl/pwr_req_ctrl.sv
module pwr_req_ctrl
    import pwr_req_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] HALT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] STBY_OFS = 8'h0C,
    parameter logic [ADDR_W-1:0] CLR_OFS  = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mode_en,
    input  logic              wdog_evt,
    input  logic              tick_evt,
    output logic              wdog_irq,
    output logic              tick_irq,
    output logic              halt_req,
    output logic              stby_req
);

    logic [NUM_MODES-1:0] mode_rd;
    logic [NUM_MODES-1:0] mode_req;
    logic                 clr_wr;
    logic [NUM_IRQS-1:0]  irq_evt;
    logic [NUM_IRQS-1:0]  irq_flag;

    // Write data carries no bits: any value triggers the clear.
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    // No location of this slice has readable bits.
    assign bus_rdata = '0;

    pwr_addr_dec #(
        .ADDR_W   (ADDR_W),
        .HALT_OFS (HALT_OFS),
        .STBY_OFS (STBY_OFS),
        .CLR_OFS  (CLR_OFS)
    ) u_dec (
        .addr_i    (bus_addr),
        .rd_i      (bus_rd),
        .wr_i      (bus_wr),
        .mode_rd_o (mode_rd),
        .clr_wr_o  (clr_wr)
    );

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_req
        pwr_req_pulse u_pulse (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (mode_rd[m]),
            .en_i     (mode_en),
            .req_o    (mode_req[m])
        );
    end

    assign irq_evt = {tick_evt, wdog_evt};

    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_irq
        pwr_irq_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (irq_evt[i]),
            .clr_i (clr_wr),
            .irq_o (irq_flag[i])
        );
    end

    assign halt_req = mode_req[0];
    assign stby_req = mode_req[1];
    assign wdog_irq = irq_flag[0];
    assign tick_irq = irq_flag[1];

    // R5/R10: without a read there is no request in the next cycle
    a_r5_no_req_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (!halt_req && !stby_req));

    // R1/R2: the two requests are never raised together
    a_r2_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, stby_req}));

    // R10: no interrupt falls without a write
    a_r10_no_clear_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && wdog_irq) |=> wdog_irq);

endmodule

// File: tb/tb_pwr_req_ctrl.sv
module tb_pwr_req_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int HALT_A = 8'h08;
    localparam int STBY_A = 8'h0C;
    localparam int CLR_A  = 8'h18;
    localparam int WDOG_LIMIT = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              mode_en = 1'b0;
    logic              wdog_evt = 1'b0;
    logic              tick_evt = 1'b0;
    logic              wdog_irq, tick_irq, halt_req, stby_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_req_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_en(mode_en), .wdog_evt(wdog_evt), .tick_evt(tick_evt),
        .wdog_irq(wdog_irq), .tick_irq(tick_irq),
        .halt_req(halt_req), .stby_req(stby_req)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    // Pulse the event inputs for one cycle, then check that the flags are set (R8).
    task automatic pulse_evt(input logic w, input logic t);
        @(negedge clk);
        wdog_evt = w;
        tick_evt = t;
        @(posedge clk); #1;
        if (w) chk("R8 wdog set", wdog_irq, 1);
        if (t) chk("R8 tick set", tick_irq, 1);
        @(negedge clk);
        wdog_evt = 0;
        tick_evt = 0;
    endtask

    // A read held for 'len' cycles: R1 R2 R3 R4 R6 R10
    task automatic do_read(input int a, input logic en, input int len);
        logic iw, it;
        iw = wdog_irq;
        it = tick_irq;
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0];
        bus_rd = 1;
        mode_en = en;
        for (int k = 0; k < len; k++) begin
            #1 chk("R6 rdata zero", bus_rdata, 0);
            @(posedge clk); #1;
            chk((a == HALT_A) ? "R1 halt pulse" : "R10 no halt", halt_req,
                (k == 0 && en && a == HALT_A) ? 1 : 0);
            chk((a == STBY_A) ? "R2 stby pulse" : "R10 no stby", stby_req,
                (k == 0 && en && a == STBY_A) ? 1 : 0);
            @(negedge clk);
        end
        bus_rd = 0;
        @(posedge clk); #1;
        chk("R4 no repeat halt", halt_req, 0);
        chk("R4 no repeat stby", stby_req, 0);
        chk("R3 irq untouched", {iw, it}, {wdog_irq, tick_irq});
    endtask

    // Write with both flags set: R5 R7 R10
    task automatic do_write(input int a, input logic [DATA_W-1:0] d);
        pulse_evt(1, 1);
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0];
        bus_wr = 1;
        bus_wdata = d;
        @(posedge clk); #1;
        chk((a == CLR_A) ? "R7 wdog clr" : "R5 wdog kept", wdog_irq, (a == CLR_A) ? 0 : 1);
        chk((a == CLR_A) ? "R7 tick clr" : "R5 tick kept", tick_irq, (a == CLR_A) ? 0 : 1);
        chk("R5 no req on write", {halt_req, stby_req}, 0);
        @(negedge clk);
        bus_wr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("reset halt_req", halt_req, 0);
        chk("reset stby_req", stby_req, 0);
        chk("reset wdog_irq", wdog_irq, 0);
        chk("reset tick_irq", tick_irq, 0);
        @(negedge clk);
        rst_n = 1;

        // R8: each flag set independently and held
        pulse_evt(1, 0);
        chk("R8 tick stays low", tick_irq, 0);
        repeat (4) @(posedge clk);
        #1 chk("R8 wdog held", wdog_irq, 1);
        pulse_evt(0, 1);

        // Read sweep over every offset, both enables, held reads
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            for (int e = 0; e < 2; e++) begin
                do_read(a, e[0], (a[0] ^ e[0]) ? 3 : 1);
            end
        end
        // Back-to-back distinct reads, R4: halt then standby
        do_read(HALT_A, 1, 3);
        do_read(STBY_A, 1, 3);

        // Write sweep over every offset with varied data
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            do_write(a, 32'h01010101 * a[7:0] ^ 32'hA5000000);
        end
        do_write(CLR_A, 32'h0);

        // R9: set wins over same-cycle clear (both flags set first)
        pulse_evt(1, 1);
        @(negedge clk);
        bus_addr = CLR_A;
        bus_wr = 1;
        wdog_evt = 1;
        @(posedge clk); #1;
        chk("R9 wdog set wins", wdog_irq, 1);
        chk("R7 tick cleared", tick_irq, 0);
        @(negedge clk);
        bus_wr = 0;
        wdog_evt = 0;
        pulse_evt(0, 1);
        @(negedge clk);
        bus_wr = 1;
        tick_evt = 1;
        @(posedge clk); #1;
        chk("R9 tick set wins", tick_irq, 1);
        chk("R7 wdog cleared", wdog_irq, 0);
        @(negedge clk);
        bus_wr = 0;
        tick_evt = 0;

        finish_run();
    end

endmodule